// File: doc/BRIEF.md
# Six-Channel Buffer Scan Arbiter

This block decides, one word at a time, who owns a single shared memory port. Six buffer channels each raise a request line while they have a word to move. A main-program requester also competes for the port. A scanner walks the channels in a fixed, non-numeric cyclic sequence. It grants the first requesting channel it meets for exactly one word, then continues the walk from the next position. Buffer channels beat the program requester. The exception is when the only requesting channel is the one that was just served. In that case the program gets one reference before that channel's next word.

Each grant is held until the transfer logic returns a one-cycle `word_done_i` pulse. The memory, address counters and channel handshakes sit outside the block. Between two grants the arbiter spends exactly one idle cycle, in which it evaluates the requests.

Top module: `buf_scan_arb`

## Requirements
- R1: After reset the scan position is channel 1 and every grant and `busy_o` are low. With all channels requesting, channel 1 wins first. Channel n is bit n-1 of `chan_req_i` and `chan_gnt_o`.
- R2: With all six channels requesting continuously, grants follow the cyclic sequence 1, 3, 2, 6, 4, 5, 1.
- R3: After serving a channel, the next search starts at the sequence position right after it and wraps from channel 5 back to channel 1.
- R4: A channel grant stays asserted and unchanged until `word_done_i` is sampled high, whatever the request inputs do meanwhile.
- R5: At most one grant, channel or program, is high in any cycle.
- R6: A program request is not granted while any channel other than the one just served is requesting.
- R7: With a single channel and the program both requesting, grants alternate between that channel and the program.
- R8: When no channel requests, a pending program request is granted one cycle after the idle cycle in which it is seen. The program grant is also released by `word_done_i`.
- R9: The channel just served is granted again only when no other channel and no program request is pending.
- R10: `busy_o` is high exactly when some grant is high.
- R11: A grant appears on the clock edge after the idle cycle in which a request is seen. After `word_done_i`, the next cycle is idle, with all grants low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chan_req_i | input | 6 | Per-channel word request, bit n-1 is channel n |
| prog_req_i | input | 1 | Main-program memory request |
| word_done_i | input | 1 | One-cycle pulse ending the current granted word |
| chan_gnt_o | output | 6 | One-hot channel grant |
| prog_gnt_o | output | 1 | Program grant |
| busy_o | output | 1 | Port owned by some requester |

## Verification
The bench goes after the scan sequence and its wrap. A design walking channels numerically would grant 2 before 3, and one restarting at channel 1 would pick channel 1 instead of 6 after a mid-sequence reload. It drops requests while a grant is held, which catches a design that pre-empts mid-word. It also mixes program requests with one or two active channels. A design that ignores the just-served channel would starve the program, and one that lets the program jump ahead would break buffer priority.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  localparam int NCH = 6;
  localparam int PW  = $clog2(NCH);

  typedef enum logic [1:0] {ST_IDLE, ST_CHAN, ST_PROG} st_e;

  // sequence position -> channel index (0-based): 1,3,2,6,4,5
  function automatic logic [PW-1:0] pos2ch(input int p);
    case (p)
      0:       pos2ch = PW'(0);
      1:       pos2ch = PW'(2);
      2:       pos2ch = PW'(1);
      3:       pos2ch = PW'(5);
      4:       pos2ch = PW'(3);
      default: pos2ch = PW'(4);
    endcase
  endfunction

  function automatic logic [PW-1:0] pos_inc(input logic [PW-1:0] p, input int k);
    int s;
    s = int'(p) + k;
    if (s >= NCH) s = s - NCH;
    pos_inc = PW'(s);
  endfunction
endpackage

// File: rtl/bscan_pick.sv
module bscan_pick
  import bscan_pkg::*;
(
  input  logic [NCH-1:0] req_i,
  input  logic [PW-1:0]  start_i,
  output logic           hit_o,
  output logic [PW-1:0]  pos_o,
  output logic [PW-1:0]  ch_o
);
  logic [NCH-1:0] pos_req;

  // requests reordered into scan-sequence order
  for (genvar g = 0; g < NCH; g++) begin : g_perm
    assign pos_req[g] = req_i[pos2ch(g)];
  end

  always_comb begin
    hit_o = 1'b0;
    pos_o = start_i;
    for (int k = NCH - 1; k >= 0; k--) begin
      if (pos_req[pos_inc(start_i, k)]) begin
        hit_o = 1'b1;
        pos_o = pos_inc(start_i, k);
      end
    end
    ch_o = pos2ch(int'(pos_o));
  end
endmodule

// File: rtl/bscan_ctrl.sv
module bscan_ctrl
  import bscan_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] chan_req_i,
  input  logic           prog_req_i,
  input  logic           word_done_i,
  input  logic           hit_i,
  input  logic [PW-1:0]  hit_pos_i,
  input  logic [PW-1:0]  hit_ch_i,
  output logic [NCH-1:0] elig_o,
  output logic [PW-1:0]  start_o,
  output logic [NCH-1:0] chan_gnt_o,
  output logic           prog_gnt_o,
  output logic           busy_o
);
  st_e           st_q, st_d;
  logic [PW-1:0] pos_q, pos_d;
  logic [PW-1:0] gch_q, gch_d;
  logic [PW-1:0] last_q, last_d;
  logic          lvld_q, lvld_d;

  // the channel just served sits out one search
  assign elig_o  = chan_req_i & ~(lvld_q ? (NCH'(1) << last_q) : '0);
  assign start_o = pos_q;

  always_comb begin
    st_d   = st_q;
    pos_d  = pos_q;
    gch_d  = gch_q;
    last_d = last_q;
    lvld_d = lvld_q;
    unique case (st_q)
      ST_IDLE: begin
        if (hit_i) begin
          st_d  = ST_CHAN;
          gch_d = hit_ch_i;
          pos_d = pos_inc(hit_pos_i, 1);
        end else if (prog_req_i) begin
          st_d   = ST_PROG;
          lvld_d = 1'b0;
        end else if (|chan_req_i) begin
          st_d  = ST_CHAN;     // only the last-served channel is asking
          gch_d = last_q;
        end
      end
      ST_CHAN: if (word_done_i) begin
        st_d   = ST_IDLE;
        last_d = gch_q;
        lvld_d = 1'b1;
      end
      default: if (word_done_i) st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pos_q  <= '0;
      gch_q  <= '0;
      last_q <= '0;
      lvld_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pos_q  <= pos_d;
      gch_q  <= gch_d;
      last_q <= last_d;
      lvld_q <= lvld_d;
    end
  end

  assign chan_gnt_o = (st_q == ST_CHAN) ? (NCH'(1) << gch_q) : '0;
  assign prog_gnt_o = (st_q == ST_PROG);
  assign busy_o     = (st_q != ST_IDLE);

  assert_gnt_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({chan_gnt_o, prog_gnt_o}));

  assert_gnt_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|chan_gnt_o && !word_done_i) |=> $stable(chan_gnt_o));

  assert_gnt_to_req_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|chan_gnt_o && !(|$past(chan_gnt_o))) |-> |(chan_gnt_o & $past(chan_req_i)));

  assert_prog_to_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_gnt_o) |-> $past(prog_req_i));

  assert_idle_gap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && word_done_i) |=> !busy_o);
endmodule

// File: rtl/buf_scan_arb.sv
module buf_scan_arb
  import bscan_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] chan_req_i,
  input  logic           prog_req_i,
  input  logic           word_done_i,
  output logic [NCH-1:0] chan_gnt_o,
  output logic           prog_gnt_o,
  output logic           busy_o
);
  logic [NCH-1:0] elig;
  logic [PW-1:0]  start, hit_pos, hit_ch;
  logic           hit;

  bscan_pick u_pick (
    .req_i   (elig),
    .start_i (start),
    .hit_o   (hit),
    .pos_o   (hit_pos),
    .ch_o    (hit_ch)
  );

  bscan_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .chan_req_i  (chan_req_i),
    .prog_req_i  (prog_req_i),
    .word_done_i (word_done_i),
    .hit_i       (hit),
    .hit_pos_i   (hit_pos),
    .hit_ch_i    (hit_ch),
    .elig_o      (elig),
    .start_o     (start),
    .chan_gnt_o  (chan_gnt_o),
    .prog_gnt_o  (prog_gnt_o),
    .busy_o      (busy_o)
  );

  assert_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (|chan_gnt_o || prog_gnt_o));
endmodule

// File: tb/tb_buf_scan_arb.sv
module tb_buf_scan_arb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] chan_req_i = '0;
  logic       prog_req_i = 1'b0;
  logic       word_done_i = 1'b0;
  logic [5:0] chan_gnt_o;
  logic       prog_gnt_o, busy_o;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  buf_scan_arb dut (.*);

  function automatic logic [5:0] ch(input int n);
    return 6'(1) << (n - 1);
  endfunction

  task automatic check(input logic [5:0] g, input logic p, input string tag);
    logic b;
    b = (|g) | p;
    n_chk++;
    if (chan_gnt_o !== g || prog_gnt_o !== p || busy_o !== b) begin
      n_fail++;
      $display("FAIL %s: gnt=%b prog=%b busy=%b expected gnt=%b prog=%b busy=%b",
               tag, chan_gnt_o, prog_gnt_o, busy_o, g, p, b);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; chan_req_i = '0; prog_req_i = 1'b0; word_done_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wait_gnt(input logic [5:0] g, input logic p, input string tag);
    @(negedge clk_i);
    check(g, p, tag);
  endtask

  task automatic finish_word();
    word_done_i = 1'b1;
    @(negedge clk_i);
    word_done_i = 1'b0;
    check('0, 1'b0, "R11 idle gap");
  endtask

  task automatic t_reset();
    do_reset();
    chan_req_i = '1;
    check('0, 1'b0, "R1 reset state");
    wait_gnt(ch(1), 1'b0, "R1 first grant channel 1");
    finish_word();
  endtask

  task automatic t_order();
    int seq[7] = '{1, 3, 2, 6, 4, 5, 1};
    do_reset();
    chan_req_i = '1;
    foreach (seq[i]) begin
      wait_gnt(ch(seq[i]), 1'b0, $sformatf("R2 order step %0d", i));
      finish_word();
    end
  endtask

  task automatic t_resume();
    do_reset();
    chan_req_i = '1;
    wait_gnt(ch(1), 1'b0, "R3 first");
    finish_word();
    wait_gnt(ch(3), 1'b0, "R3 second");
    chan_req_i = ch(1) | ch(6);
    finish_word();
    wait_gnt(ch(6), 1'b0, "R3 resume after served position");
    finish_word();
    wait_gnt(ch(1), 1'b0, "R3 wrap to channel 1");
    finish_word();
  endtask

  task automatic t_hold();
    do_reset();
    chan_req_i = ch(4);
    wait_gnt(ch(4), 1'b0, "R4 grant");
    chan_req_i = ch(2);
    prog_req_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      check(ch(4), 1'b0, "R4 held without done");
    end
    chan_req_i = '0;
    finish_word();
    wait_gnt('0, 1'b1, "R8 program with no channel");
    prog_req_i = 1'b0;
    @(negedge clk_i);
    check('0, 1'b1, "R8 program held");
    finish_word();
    @(negedge clk_i);
    check('0, 1'b0, "R8 idle when nobody asks");
  endtask

  task automatic t_prio();
    do_reset();
    chan_req_i = ch(2) | ch(5);
    prog_req_i = 1'b1;
    wait_gnt(ch(2), 1'b0, "R6 first channel");
    finish_word();
    wait_gnt(ch(5), 1'b0, "R6 other channel beats program");
    finish_word();
    wait_gnt(ch(2), 1'b0, "R6 program still waits");
    chan_req_i = '0;
    finish_word();
    wait_gnt('0, 1'b1, "R6 program after channels stop");
    prog_req_i = 1'b0;
    finish_word();
  endtask

  task automatic t_single();
    do_reset();
    chan_req_i = ch(6);
    prog_req_i = 1'b1;
    for (int i = 0; i < 2; i++) begin
      wait_gnt(ch(6), 1'b0, "R7 channel turn");
      finish_word();
      wait_gnt('0, 1'b1, "R7 program turn");
      finish_word();
    end
    prog_req_i = 1'b0;
    wait_gnt(ch(6), 1'b0, "R9 channel");
    finish_word();
    wait_gnt(ch(6), 1'b0, "R9 regrant when alone");
    finish_word();
    chan_req_i = '0;
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_order();
    t_resume();
    t_hold();
    t_prio();
    t_single();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule